// File: doc/BRIEF.md
# Dual-Direction FIFO Flag Generator and Pin Router

This block watches two independent FIFOs, one moving data from side A to side B and one moving it back. It takes a free-running write pointer and read pointer for each FIFO and computes the fill level from them. From each fill level it derives four status flags: empty, almost-empty, almost-full and full. The two almost thresholds of each FIFO come from offset inputs and may be set anywhere from zero to the full depth.

The eight internal flags are presented active-high as a vector. A bank of external flag pins can each show any one of the eight. Each pin has its own polarity. One pin, pin 0 by default, can instead carry a parity-error indication when parity checking is enabled and the override is selected. The FIFO storage and the register bus that holds the configuration are outside the block, so every configuration field arrives as a plain input.

Top module: `fifo_flag_router`

## Requirements
- R1: The fill level of each FIFO is its write pointer minus its read pointer, modulo 2^(log2(DEPTH)+1), and never exceeds DEPTH. The empty flag is set exactly when the fill level is 0.
- R2: The full flag is set exactly when the fill level equals DEPTH. Full and empty are never set together.
- R3: The almost-empty flag is set when the fill level is less than or equal to that FIFO's empty offset. An offset of 0 makes it follow the empty flag.
- R4: The almost-full flag is set when the fill level plus that FIFO's full offset is at least DEPTH. An offset of 0 makes it follow the full flag, and an offset of DEPTH keeps it set.
- R5: The flags change on the first rising clock edge after the pointers or offsets change, and not before. In `flags_o`, bit {d,c} holds code c of direction d.
- R6: Pin i shows the flag chosen by `pin_sel[3i+2:3i]`. Bit 2 of the code picks the direction: 0 for A-to-B, 1 for B-to-A. Bits 1:0 pick the flag: 00 empty, 01 almost-empty, 10 almost-full, 11 full.
- R7: When `pin_pol[i]` is 0, pin i is driven high when its flag is set. When `pin_pol[i]` is 1, the pin is driven low when its flag is set. Polarity changes take effect without a clock edge.
- R8: When both `parity_en` and `parity_route` are 1, pin 0 shows, at the pin's polarity, the value `parity_err` had at the last rising clock edge. Otherwise pin 0 follows R6. The parity error never reaches any other pin.
- R9: While reset is asserted, and immediately after reset, both directions show the empty pattern: empty=1, almost-empty=1, almost-full=0, full=0. This makes `flags_o` equal 8'h33.
- R10: The two directions are independent: the pointers and offsets of one FIFO do not change the flags of the other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ab_wr_ptr | input | PW | A-to-B write pointer (PW = log2(DEPTH)+1) |
| ab_rd_ptr | input | PW | A-to-B read pointer |
| ba_wr_ptr | input | PW | B-to-A write pointer |
| ba_rd_ptr | input | PW | B-to-A read pointer |
| ab_ae_off | input | PW | A-to-B almost-empty offset |
| ab_af_off | input | PW | A-to-B almost-full offset |
| ba_ae_off | input | PW | B-to-A almost-empty offset |
| ba_af_off | input | PW | B-to-A almost-full offset |
| pin_sel | input | 3*NPINS | Flag select code, 3 bits per pin |
| pin_pol | input | NPINS | Per-pin polarity, 1 = active low |
| parity_en | input | 1 | Parity checking enabled |
| parity_route | input | 1 | Route the parity error to pin 0 |
| parity_err | input | 1 | Parity error indication |
| flags_o | output | 8 | Registered internal flags, active high |
| pin_o | output | NPINS | External flag pins |

## Verification
The assertions check on every cycle that the fill level stays within the FIFO depth. They also check that full and empty exclude each other, that empty implies almost-empty, and that full implies almost-full. A further check confirms that every pin agrees with the flag, polarity and parity override selected for it. The bench scenarios cover the behaviour an invariant cannot express: the exact threshold crossings for given offsets, pointer wrap-around, the one-edge update latency, the reset pattern and the independence of the two directions.

// File: rtl/fflag_pkg.sv
package fflag_pkg;

   localparam int NUM_DIRS      = 2;
   localparam int FLAGS_PER_DIR = 4;
   localparam int NUM_FLAGS     = NUM_DIRS * FLAGS_PER_DIR;
   localparam int SEL_W         = $clog2(NUM_FLAGS);

   typedef enum logic [1:0] {
      FL_EMPTY  = 2'd0,
      FL_AEMPTY = 2'd1,
      FL_AFULL  = 2'd2,
      FL_FULL   = 2'd3
   } flag_code_e;

   // packed: empty lands in bit 0, full in bit 3
   typedef struct packed {
      logic full;
      logic afull;
      logic aempty;
      logic empty;
   } dir_flags_t;

   function automatic dir_flags_t idle_flags();
      dir_flags_t f;
      f.full   = 1'b0;
      f.afull  = 1'b0;
      f.aempty = 1'b1;
      f.empty  = 1'b1;
      return f;
   endfunction

endpackage

// File: rtl/fflag_level.sv
module fflag_level
   import fflag_pkg::*;
#(
   parameter int DEPTH = 16,
   parameter int PW    = $clog2(DEPTH) + 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [PW-1:0] wr_ptr,
   input  logic [PW-1:0] rd_ptr,
   input  logic [PW-1:0] ae_off,
   input  logic [PW-1:0] af_off,
   output dir_flags_t    flags_q
);

   localparam logic [PW-1:0] DEPTH_V  = PW'(DEPTH);
   localparam logic [PW:0]   DEPTH_WX = (PW+1)'(DEPTH);

   logic [PW-1:0] fill;
   logic [PW:0]   af_sum;
   dir_flags_t    flags_d;

   assign fill   = wr_ptr - rd_ptr;
   assign af_sum = {1'b0, fill} + {1'b0, af_off};

   always_comb begin
      flags_d.empty  = (fill == '0);
      flags_d.full   = (fill == DEPTH_V);
      flags_d.aempty = (fill <= ae_off);
      flags_d.afull  = (af_sum >= DEPTH_WX);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flags_q <= idle_flags();
      else        flags_q <= flags_d;
   end

   assert_fill_legal_R1: assert property (@(posedge clk) disable iff (!rst_n)
      fill <= DEPTH_V);

   assert_full_not_empty_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !(flags_q.full && flags_q.empty));

   assert_empty_in_ae_R3: assert property (@(posedge clk) disable iff (!rst_n)
      flags_q.empty |-> flags_q.aempty);

   assert_full_in_af_R4: assert property (@(posedge clk) disable iff (!rst_n)
      flags_q.full |-> flags_q.afull);

endmodule

// File: rtl/fflag_pin_mux.sv
module fflag_pin_mux
   import fflag_pkg::*;
(
   input  logic [NUM_FLAGS-1:0] flags,
   input  logic [SEL_W-1:0]     sel,
   input  logic                 pol,
   input  logic                 ovr_en,
   input  logic                 ovr_val,
   output logic                 pin
);

   logic picked;

   always_comb begin
      picked = ovr_en ? ovr_val : flags[sel];
      pin    = picked ^ pol;
   end

endmodule

// File: rtl/fifo_flag_router.sv
module fifo_flag_router
   import fflag_pkg::*;
#(
   parameter int DEPTH      = 16,
   parameter int NPINS      = 4,
   parameter int PARITY_PIN = 0,
   parameter int AW         = $clog2(DEPTH),
   parameter int PW         = AW + 1
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [PW-1:0]          ab_wr_ptr,
   input  logic [PW-1:0]          ab_rd_ptr,
   input  logic [PW-1:0]          ba_wr_ptr,
   input  logic [PW-1:0]          ba_rd_ptr,
   input  logic [PW-1:0]          ab_ae_off,
   input  logic [PW-1:0]          ab_af_off,
   input  logic [PW-1:0]          ba_ae_off,
   input  logic [PW-1:0]          ba_af_off,
   input  logic [SEL_W*NPINS-1:0] pin_sel,
   input  logic [NPINS-1:0]       pin_pol,
   input  logic                   parity_en,
   input  logic                   parity_route,
   input  logic                   parity_err,
   output logic [NUM_FLAGS-1:0]   flags_o,
   output logic [NPINS-1:0]       pin_o
);

   if (DEPTH < 2 || (1 << AW) != DEPTH) begin : g_bad_depth
      $error("fifo_flag_router: DEPTH must be a power of two, at least 2");
   end
   if (NPINS < 1) begin : g_bad_npins
      $error("fifo_flag_router: NPINS must be at least 1");
   end
   if (PARITY_PIN < 0 || PARITY_PIN >= NPINS) begin : g_bad_ppin
      $error("fifo_flag_router: PARITY_PIN out of range");
   end

   logic [PW-1:0] wr_v  [NUM_DIRS];
   logic [PW-1:0] rd_v  [NUM_DIRS];
   logic [PW-1:0] aeo_v [NUM_DIRS];
   logic [PW-1:0] afo_v [NUM_DIRS];
   dir_flags_t    dflags[NUM_DIRS];

   assign wr_v[0]  = ab_wr_ptr;
   assign rd_v[0]  = ab_rd_ptr;
   assign aeo_v[0] = ab_ae_off;
   assign afo_v[0] = ab_af_off;
   assign wr_v[1]  = ba_wr_ptr;
   assign rd_v[1]  = ba_rd_ptr;
   assign aeo_v[1] = ba_ae_off;
   assign afo_v[1] = ba_af_off;

   for (genvar d = 0; d < NUM_DIRS; d++) begin : g_dir
      fflag_level #(.DEPTH(DEPTH), .PW(PW)) u_level (
         .clk     (clk),
         .rst_n   (rst_n),
         .wr_ptr  (wr_v[d]),
         .rd_ptr  (rd_v[d]),
         .ae_off  (aeo_v[d]),
         .af_off  (afo_v[d]),
         .flags_q (dflags[d])
      );
      assign flags_o[d*FLAGS_PER_DIR +: FLAGS_PER_DIR] = dflags[d];
   end

   logic par_err_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) par_err_q <= 1'b0;
      else        par_err_q <= parity_err;
   end

   logic par_show;
   assign par_show = parity_en & parity_route;

   for (genvar p = 0; p < NPINS; p++) begin : g_pin
      logic [SEL_W-1:0] sel_p;
      logic             ovr_p;
      assign sel_p = pin_sel[p*SEL_W +: SEL_W];

      if (p == PARITY_PIN) begin : g_ovr
         assign ovr_p = par_show;
         assert_parity_pin_R8: assert property (@(posedge clk) disable iff (!rst_n)
            par_show |-> (pin_o[p] == (par_err_q ^ pin_pol[p])));
      end else begin : g_plain
         assign ovr_p = 1'b0;
      end

      fflag_pin_mux u_mux (
         .flags   (flags_o),
         .sel     (sel_p),
         .pol     (pin_pol[p]),
         .ovr_en  (ovr_p),
         .ovr_val (par_err_q),
         .pin     (pin_o[p])
      );

      assert_pin_route_R6: assert property (@(posedge clk) disable iff (!rst_n)
         !ovr_p |-> (pin_o[p] == (flags_o[sel_p] ^ pin_pol[p])));
   end

endmodule

// File: tb/fifo_flag_router_test.sv
module fifo_flag_router_test;

   localparam int CLK_PERIOD = 10;
   localparam int D  = 16;
   localparam int PW = 5;
   localparam int NP = 4;

   logic          clk = 1'b0;
   logic          rst_n;
   logic [PW-1:0] ab_wr, ab_rd, ba_wr, ba_rd;
   logic [PW-1:0] ab_ae, ab_af, ba_ae, ba_af;
   logic [3*NP-1:0] sel;
   logic [NP-1:0] pol;
   logic          p_en, p_route, p_err;
   logic [7:0]    flags;
   logic [NP-1:0] pins;

   int errors = 0;
   int checks = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   fifo_flag_router #(.DEPTH(D), .NPINS(NP)) uut (
      .clk(clk), .rst_n(rst_n),
      .ab_wr_ptr(ab_wr), .ab_rd_ptr(ab_rd), .ba_wr_ptr(ba_wr), .ba_rd_ptr(ba_rd),
      .ab_ae_off(ab_ae), .ab_af_off(ab_af), .ba_ae_off(ba_ae), .ba_af_off(ba_af),
      .pin_sel(sel), .pin_pol(pol),
      .parity_en(p_en), .parity_route(p_route), .parity_err(p_err),
      .flags_o(flags), .pin_o(pins)
   );

   function automatic logic [3:0] model(int fill, int ae, int af);
      return {fill == D, (fill + af) >= D, fill <= ae, fill == 0};
   endfunction

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   task automatic drive_ab(int wr, int rd);
      @(negedge clk);
      ab_wr = PW'(wr);
      ab_rd = PW'(rd);
      tick();
   endtask

   task automatic test_reset();
      rst_n = 1'b0;
      sel = {3'd3, 3'd2, 3'd1, 3'd0};
      pol = '0;
      repeat (2) @(posedge clk);
      #1;
      chk("R9 flags in reset", 32'(flags), 32'h33);
      chk("R9 pins in reset", 32'(pins), 32'b0011);
      @(negedge clk);
      rst_n = 1'b1;
      tick();
      chk("R9 flags after reset", 32'(flags), 32'h33);
   endtask

   task automatic test_levels();
      int ks[8] = '{0, 1, 3, 4, 11, 12, 15, 16};
      ab_ae = 5'd3;
      ab_af = 5'd4;
      foreach (ks[i]) begin
         drive_ab(ks[i], 0);
         chk("R1 R2 R3 R4 level", 32'(flags[3:0]), 32'(model(ks[i], 3, 4)));
         chk("R10 other direction", 32'(flags[7:4]), 32'h3);
      end
   endtask

   task automatic test_wrap();
      drive_ab(12, 28);
      chk("R1 R2 wrap full", 32'(flags[3:0]), 32'b1100);
      drive_ab(1, 30);
      chk("R1 wrap fill 3", 32'(flags[3:0]), 32'b0010);
      @(negedge clk);
      ba_wr = 5'd15; ba_rd = 5'd5; ba_ae = 5'd2; ba_af = 5'd6;
      tick();
      chk("R10 ba fill 10", 32'(flags[7:4]), 32'b0100);
      chk("R10 ab unchanged", 32'(flags[3:0]), 32'b0010);
   endtask

   task automatic test_offsets();
      ab_ae = 5'd0;
      ab_af = 5'd0;
      drive_ab(0, 0);
      chk("R3 R4 zero offsets empty", 32'(flags[3:0]), 32'b0011);
      drive_ab(1, 0);
      chk("R3 zero offset fill 1", 32'(flags[3:0]), 32'b0000);
      drive_ab(15, 0);
      chk("R4 zero offset fill 15", 32'(flags[3:0]), 32'b0000);
      drive_ab(16, 0);
      chk("R4 zero offset full", 32'(flags[3:0]), 32'b1100);
      @(negedge clk);
      ab_af = 5'd16;
      ab_wr = '0; ab_rd = '0;
      tick();
      chk("R4 offset equals depth", 32'(flags[3:0]), 32'b0111);
   endtask

   task automatic test_latency();
      ab_ae = 5'd3; ab_af = 5'd4;
      drive_ab(0, 0);
      @(negedge clk);
      ab_wr = 5'd16;
      #1;
      chk("R5 no change before edge", 32'(flags[3:0]), 32'b0011);
      tick();
      chk("R5 change at edge", 32'(flags[3:0]), 32'b1100);
   endtask

   task automatic test_pin_map();
      logic [7:0] exp8;
      drive_ab(3, 0);
      exp8 = {4'b1100, 4'b0010};
      @(negedge clk);
      ba_wr = 5'd16; ba_rd = 5'd0;
      tick();
      for (int s = 0; s < 8; s++) begin
         @(negedge clk);
         sel[8:6] = 3'(s);
         #1;
         chk("R6 pin 2 select", 32'(pins[2]), 32'(exp8[s]));
      end
   endtask

   task automatic test_polarity();
      @(negedge clk);
      sel = {3'd1, 3'd1, 3'd1, 3'd1};
      pol = 4'b1010;
      #1;
      chk("R7 mixed polarity", 32'(pins), 32'b0101);
      pol = 4'b0000;
      #1;
      chk("R7 active high", 32'(pins), 32'b1111);
   endtask

   task automatic test_parity();
      @(negedge clk);
      sel = {3'd1, 3'd1, 3'd1, 3'd0};
      pol = 4'b0000;
      p_en = 1'b1; p_route = 1'b1; p_err = 1'b1;
      #1;
      chk("R8 parity before edge", 32'(pins), 32'b1110);
      tick();
      chk("R8 parity on pin 0 only", 32'(pins), 32'b1111);
      @(negedge clk);
      pol[0] = 1'b1;
      #1;
      chk("R8 parity with polarity", 32'(pins[0]), 32'b0);
      pol[0] = 1'b0;
      p_en = 1'b0;
      #1;
      chk("R8 disabled parity ignored", 32'(pins[0]), 32'b0);
      p_en = 1'b1; p_route = 1'b0;
      #1;
      chk("R8 unrouted parity ignored", 32'(pins[0]), 32'b0);
      p_err = 1'b0;
   endtask

   task automatic test_midrun_reset();
      drive_ab(16, 0);
      @(negedge clk);
      rst_n = 1'b0;
      #1;
      chk("R9 async reset", 32'(flags), 32'h33);
      @(negedge clk);
      ab_wr = '0;
      ba_wr = '0;
      rst_n = 1'b1;
      tick();
      chk("R9 after release", 32'(flags), 32'h33);
   endtask

   initial begin
      ab_wr = '0; ab_rd = '0; ba_wr = '0; ba_rd = '0;
      ab_ae = 5'd3; ab_af = 5'd4; ba_ae = 5'd2; ba_af = 5'd6;
      p_en = 1'b0; p_route = 1'b0; p_err = 1'b0;
      test_reset();
      test_levels();
      test_wrap();
      test_offsets();
      test_latency();
      test_pin_map();
      test_polarity();
      test_parity();
      test_midrun_reset();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 100000);
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule